// File: doc/BRIEF.md
# Sub-Pixel Convolution Upscaler

This block enlarges a single-channel luma feature map by an integer factor S. A strided transposed convolution is replaced by S² small K×K convolutions, one per output sub-pixel phase. All S² convolutions run side by side on the same low-resolution window. Their results are woven into one high-resolution raster stream. Because each output block is produced whole, no overlapping partial sums are ever built up, and all storage stays on chip.

Operation has three parts:

- Software fills the weight register file through a small write port while the block is idle. Weights are already rearranged into per-phase kernels, with the unused positions set to zero.
- A low-resolution frame is streamed in with a valid/ready handshake, marked by a start-of-frame bit.
- The block works through one low-resolution row at a time. Each cycle it evaluates all phases for one pixel into an S-row staging buffer. It then drains that buffer in high-resolution raster order, adding start-of-frame and end-of-line flags.

Data and weights are 13-bit signed fixed point with 8 fractional bits.

Top module: `subpix_upscaler`

## Requirements
- R1: After reset, out_valid and busy are 0 and in_ready is 1.
- R2: A weight write (wr_en=1) is stored only while busy is 0. The address is phase*K*K + ky*K + kx, with phase = dy*S+dx. A write made while busy is 1 has no effect on any later output.
- R3: A frame starts only with a pixel accepted while busy is 0 and in_sof is 1. Pixels accepted while idle with in_sof=0 are dropped. After IMG_W*IMG_H pixels, in_ready stays 0 until the frame's last output pixel has been presented.
- R4: Each output is the full-precision sum of K*K weight×pixel products, rounded to nearest (add 2^7, then arithmetic shift right by 8) and saturated to [-4096, 4095].
- R5: Window taps at low-resolution positions outside the image contribute zero.
- R6: Each phase is applied to a window centred on its low-resolution pixel (x,y), with tap (ky,kx) reading pixel (x+kx-1, y+ky-1). Phase p=dy*S+dx of that pixel appears at high-resolution position (S*x+dx, S*y+dy). Outputs leave in high-resolution raster order, S*IMG_W*S*IMG_H pixels per frame.
- R7: out_sof is 1 only on the first output pixel of a frame. out_eol is 1 only on the last pixel of each high-resolution row.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sof and out_eol hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts an input pixel |
| in_data | input | 13 | Low-resolution luma pixel, signed Q4.8 |
| in_sof | input | 1 | First pixel of a frame |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | WAW | Weight index |
| wr_data | input | 13 | Weight value, signed Q4.8 |
| busy | output | 1 | A frame is being loaded, computed or drained |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer accepts output pixel |
| out_data | output | 13 | High-resolution pixel, signed Q4.8 |
| out_sof | output | 1 | First output pixel of the frame |
| out_eol | output | 1 | Last pixel of a high-resolution row |

## Verification
A wrong internal state shows up in different ways:

- A slipped column or row counter puts phases in the wrong high-resolution slots. The first affected row then carries wrong values, and out_eol sits at the wrong place in that same row.
- A bad window edge corrupts the first or last pixel pair of a row as soon as that row drains.
- A weight write leaking through while busy alters every later frame at the phase it touched.
- Rounding or saturation faults appear on the first pixel whose sum crosses a half step or the 13-bit limit.

Sweeping every output pixel of frames with mixed, saturating and back-pressured traffic catches each of these within one frame.

// File: rtl/subpix_pkg.sv
package subpix_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CALC, ST_DRAIN} sp_state_t;
endpackage

// File: rtl/subpix_wregs.sv
module subpix_wregs #(
  parameter int NW  = 36,
  parameter int DW  = 13,
  parameter int WAW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [WAW-1:0]     waddr,
  input  logic [DW-1:0]      wdata,
  output logic [NW*DW-1:0]   wflat
);
  logic [DW-1:0] wr [NW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) wr[i] <= '0;
    end else if (we && (int'(waddr) < NW)) begin
      wr[waddr] <= wdata;
    end
  end

  generate
    for (genvar i = 0; i < NW; i++) begin : g_flat
      assign wflat[i*DW +: DW] = wr[i];
    end
  endgenerate
endmodule

// File: rtl/subpix_mac.sv
module subpix_mac #(
  parameter int DW   = 13,
  parameter int FRAC = 8,
  parameter int NT   = 9
) (
  input  logic [NT*DW-1:0]     taps,
  input  logic [NT*DW-1:0]     wts,
  output logic [DW-1:0]        res
);
  localparam int ACW = 2*DW + $clog2(NT) + 1;
  localparam logic signed [ACW-1:0] MAXV = ACW'((2**(DW-1)) - 1);
  localparam logic signed [ACW-1:0] MINV = -MAXV - ACW'(1);
  localparam logic signed [ACW-1:0] HALF = ACW'(1) <<< (FRAC-1);

  logic signed [ACW-1:0] acc, shf;

  always_comb begin
    acc = '0;
    for (int t = 0; t < NT; t++) begin
      acc = acc + ACW'($signed(taps[t*DW +: DW]) * $signed(wts[t*DW +: DW]));
    end
    shf = (acc + HALF) >>> FRAC;
    if (shf > MAXV)      res = MAXV[DW-1:0];
    else if (shf < MINV) res = MINV[DW-1:0];
    else                 res = shf[DW-1:0];
  end
endmodule

// File: rtl/subpix_upscaler.sv
module subpix_upscaler #(
  parameter int IMG_W = 6,
  parameter int IMG_H = 4,
  parameter int S     = 2,
  parameter int KC    = 3,
  parameter int DW    = 13,
  parameter int FRAC  = 8,
  parameter int WAW   = $clog2(S*S*KC*KC + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  input  logic           in_sof,
  input  logic           wr_en,
  input  logic [WAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic           busy,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [DW-1:0]  out_data,
  output logic           out_sof,
  output logic           out_eol
);
  import subpix_pkg::*;

  localparam int NPIX = IMG_W * IMG_H;
  localparam int NPH  = S * S;
  localparam int NT   = KC * KC;
  localparam int NW   = NPH * NT;
  localparam int HRW  = S * IMG_W;
  localparam int RB   = S * HRW;
  localparam int LW   = $clog2(NPIX + 1);
  localparam int XW   = $clog2(IMG_W + 1);
  localparam int YW   = $clog2(IMG_H + 1);
  localparam int RBW  = $clog2(RB + 1);
  localparam int HCW  = $clog2(HRW + 1);
  localparam int HK   = KC / 2;

  sp_state_t      st;
  logic [LW-1:0]  ld;
  logic [XW-1:0]  cx;
  logic [YW-1:0]  cy;
  logic [RBW-1:0] dc;
  logic [HCW-1:0] hc;

  logic [DW-1:0]    lrbuf  [NPIX];
  logic [DW-1:0]    rowbuf [RB];
  logic [NW*DW-1:0] wflat;
  logic [NT*DW-1:0] win;
  logic [DW-1:0]    ph_res [NPH];
  logic [RBW-1:0]   wix    [NPH];
  logic [LW-1:0]    lr_wa;
  int rr, cc;

  assign in_ready = (st == ST_IDLE) || (st == ST_LOAD);
  assign busy     = (st != ST_IDLE);

  subpix_wregs #(.NW(NW), .DW(DW), .WAW(WAW)) u_wregs (
    .clk(clk), .rst(rst), .we(wr_en && !busy),
    .waddr(wr_addr), .wdata(wr_data), .wflat(wflat)
  );

  // Window gather with zero fill outside the image
  always_comb begin
    win = '0;
    rr  = 0;
    cc  = 0;
    for (int ky = 0; ky < KC; ky++) begin
      for (int kx = 0; kx < KC; kx++) begin
        rr = int'(cy) + ky - HK;
        cc = int'(cx) + kx - HK;
        if (rr >= 0 && rr < IMG_H && cc >= 0 && cc < IMG_W)
          win[(ky*KC + kx)*DW +: DW] = lrbuf[LW'(rr*IMG_W + cc)];
      end
    end
  end

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      subpix_mac #(.DW(DW), .FRAC(FRAC), .NT(NT)) u_mac (
        .taps(win), .wts(wflat[p*NT*DW +: NT*DW]), .res(ph_res[p])
      );
      assign wix[p] = RBW'((p / S) * HRW + S * int'(cx) + (p % S));
    end
  endgenerate

  assign lr_wa = (st == ST_IDLE) ? '0 : ld;

  always_ff @(posedge clk) begin
    if (in_valid && in_ready && (st == ST_LOAD || in_sof))
      lrbuf[lr_wa] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (st == ST_CALC) begin
      for (int p = 0; p < NPH; p++) rowbuf[wix[p]] <= ph_res[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ld        <= '0;
      cx        <= '0;
      cy        <= '0;
      dc        <= '0;
      hc        <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (in_valid && in_sof) begin
            ld <= LW'(1);
            cx <= '0;
            cy <= '0;
            st <= (NPIX == 1) ? ST_CALC : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (in_valid) begin
            ld <= ld + LW'(1);
            if (ld == LW'(NPIX - 1)) st <= ST_CALC;
          end
        end
        ST_CALC: begin
          if (cx == XW'(IMG_W - 1)) begin
            cx <= '0;
            dc <= '0;
            hc <= '0;
            st <= ST_DRAIN;
          end else begin
            cx <= cx + XW'(1);
          end
        end
        default: begin
          if (!out_valid || out_ready) begin
            out_valid <= 1'b1;
            out_data  <= rowbuf[dc];
            out_sof   <= (cy == '0) && (dc == '0);
            out_eol   <= (hc == HCW'(HRW - 1));
            hc        <= (hc == HCW'(HRW - 1)) ? '0 : hc + HCW'(1);
            dc        <= dc + RBW'(1);
            if (dc == RBW'(RB - 1)) begin
              if (cy == YW'(IMG_H - 1)) begin
                st <= ST_IDLE;
              end else begin
                cy <= cy + YW'(1);
                st <= ST_CALC;
              end
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/subpix_upscaler_chk.sv
module subpix_upscaler_chk #(
  parameter int HRW = 12,
  parameter int DW  = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_sof,
  input logic          busy,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sof,
  input logic          out_eol
);
  localparam int CW = $clog2(HRW + 1);
  logic [CW-1:0] lcnt;

  always_ff @(posedge clk) begin
    if (rst) lcnt <= '0;
    else if (out_valid && out_ready) lcnt <= out_eol ? '0 : lcnt + CW'(1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !busy && in_ready));

  p_sof_starts_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && in_valid && in_ready && in_sof) |=> busy);

  p_drop_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && in_valid && !in_sof) |=> !busy);

  p_no_input_on_output_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> !in_ready);

  p_eol_place_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_eol) |-> (lcnt == CW'(HRW - 1)));

  p_eol_missing_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_eol) |-> (lcnt != CW'(HRW - 1)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sof) && $stable(out_eol)));
endmodule

bind subpix_upscaler subpix_upscaler_chk #(.HRW(S*IMG_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/subpix_upscaler_test.sv
`timescale 1ns/1ps
module subpix_upscaler_test;
  localparam int W = 6, H = 4, S = 2, K = 3, DW = 13;
  localparam int NT = K*K, NW = S*S*NT, HRW = S*W, NOUT = HRW*S*H;
  localparam int WAW = $clog2(NW + 1);

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_sof = 0, wr_en = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0, wr_data = '0;
  logic [WAW-1:0] wr_addr = '0;
  logic in_ready, busy, out_valid, out_sof, out_eol;
  logic [DW-1:0] out_data;

  int pix [H][W];
  int wt [NW];
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  subpix_upscaler uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(input int idx);
    int X, Y, x, y, p, r, c;
    longint sum, q;
    X = idx % HRW; Y = idx / HRW;
    x = X / S; y = Y / S;
    p = (Y % S) * S + (X % S);
    sum = 0;
    for (int ky = 0; ky < K; ky++)
      for (int kx = 0; kx < K; kx++) begin
        r = y + ky - 1; c = x + kx - 1;
        if (r >= 0 && r < H && c >= 0 && c < W)   // R5 zero fill
          sum += longint'(wt[p*NT + ky*K + kx]) * longint'(pix[r][c]);
      end
    q = (sum + 128) >>> 8;                        // R4 round
    if (q > 4095) q = 4095;
    if (q < -4096) q = -4096;
    return int'(q);
  endfunction

  task automatic load_weights();
    for (int i = 0; i < NW; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = WAW'(i); wr_data = DW'(wt[i]);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send_px(input int d, input bit sof);
    @(negedge clk);
    while (!in_ready) begin
      in_valid = 0;
      @(negedge clk);
    end
    in_valid = 1; in_data = DW'(d); in_sof = sof;
  endtask

  task automatic send_frame(input bit poke_weight);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        send_px(pix[y][x], (x == 0 && y == 0));
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    chk(!in_ready, "R3 in_ready low after frame", int'(in_ready), 0);
    chk(busy, "R3 busy after frame", int'(busy), 1);
    if (poke_weight) begin
      wr_en = 1; wr_addr = WAW'(4); wr_data = DW'(1234);  // R2 ignored while busy
      @(negedge clk);
      wr_en = 0;
    end
  endtask

  task automatic recv_frame(input int mode, input string tag);
    int idx;
    idx = 0;
    while (idx < NOUT) begin
      @(negedge clk);
      out_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (out_valid && out_ready) begin
        chk($signed(out_data) == model(idx), {tag, " R6 data"},
            int'($signed(out_data)), model(idx));
        chk(out_sof == (idx == 0), {tag, " R7 sof"}, int'(out_sof), int'(idx == 0));
        chk(out_eol == ((idx % HRW) == HRW-1), {tag, " R7 eol"},
            int'(out_eol), int'((idx % HRW) == HRW-1));
        idx++;
      end
    end
    @(negedge clk);
    out_ready = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(in_ready, "R1 in_ready", int'(in_ready), 1);

    // Frame 1: mixed weights and pixels; stray pixel before sof is dropped (R3)
    for (int i = 0; i < NW; i++) wt[i] = ((i*37 + 11) % 511) - 255;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) pix[y][x] = ((x*53 + y*97 + 5) % 801) - 400;
    load_weights();
    send_px(3000, 0);
    @(negedge clk);
    in_valid = 0;
    chk(!busy, "R3 stray pixel ignored", int'(busy), 0);
    fork
      send_frame(0);
      recv_frame(0, "F1 R4 R5");
    join

    // Frame 2: saturation toward both limits (R4)
    for (int i = 0; i < NW; i++) wt[i] = (i % 2) ? 4095 : 2000;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) pix[y][x] = ((x + y) % 3 == 0) ? 4095 : -4096;
    load_weights();
    fork
      send_frame(0);
      recv_frame(0, "F2 R4 sat");
    join

    // Frame 3: weight write during busy ignored (R2), output back-pressure (R8)
    for (int i = 0; i < NW; i++) wt[i] = ((i*37 + 11) % 511) - 255;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) pix[y][x] = ((x*131 + y*71) % 1201) - 600;
    load_weights();
    fork
      send_frame(1);
      recv_frame(1, "F3 R2 R8");
    join

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule